// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Triggers

A 32-pin general-purpose I/O port sitting behind a single-cycle register port. Software sets an output value and a direction per pin. It reads back the synchronised level of every pad, whatever that pad's direction. Each pin can also raise an interrupt. A 2-bit trigger field per pin chooses low level, high level, rising edge or falling edge. Detected conditions latch into a sticky status word, and software clears that word by writing ones to it.

A mask word gates the pending flags onto two request lines, one for each 16-pin half of the port, and onto a combined request. Pads pass through a two-flop synchroniser first. Edges are found by comparing the synchronised sample with the one from the cycle before. A level condition keeps setting its status bit on every cycle while it lasts.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the output data, direction, mask and both trigger-configuration words read as zero, `pad_oe_o` and `pad_o` are zero, and all three interrupt requests are low.
- R2: The output data word (byte offset 0x00) and the direction word (offset 0x04) read back what was written. `pad_oe_o` equals the direction word (1 = output). `pad_o` carries a data bit only where the direction bit is 1, and is 0 elsewhere.
- R3: Offset 0x08 returns each pad level two clock edges after it was sampled, for inputs and outputs alike. Writes to offset 0x08 change nothing.
- R4: Offset 0x0C holds trigger fields for pins 0–15 and offset 0x10 holds them for pins 16–31. Pin n uses bits [2(n mod 16)+1 : 2(n mod 16)] of its word. Both words read back what was written.
- R5: Trigger code 0 flags a low level, 1 a high level, 2 a 0→1 change and 3 a 1→0 change of the synchronised sample. The change is measured between consecutive cycles.
- R6: The status word (offset 0x18) is sticky. A flagged bit stays 1 after the condition that set it has gone.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R8: When a detection and a clear reach the same status bit in the same cycle, the bit stays set. As a result, a bit whose level condition still holds cannot be cleared.
- R9: The mask word sits at offset 0x14. `irq_lo_o` is the OR of status AND mask over pins 0–15, `irq_hi_o` is the same over pins 16–31, and `irq_o` is their OR.
- R10: Any other address, including a misaligned one, reads as zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address of the register access |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| pad_i | input | 32 | Pad levels, asynchronous |
| pad_o | output | 32 | Value driven to the pads |
| pad_oe_o | output | 32 | Pad output enable, 1 = drive |
| irq_lo_o | output | 1 | Request from pins 0–15 |
| irq_hi_o | output | 1 | Request from pins 16–31 |
| irq_o | output | 1 | Combined request |

## Verification
The trigger logic is run six times. In four runs every pin shares one trigger code. In two runs the codes are mixed per pin by formula, so a field placed at the wrong bit position or in the wrong word shows up as a wrong pin.

Within each run, a series of pad words mixes 0→1 and 1→0 changes with unchanged pins. This separates edge detection from level detection, and rising from falling. Partial clears follow each pad change. They show W1C behaviour, stickiness, and the way a persisting level overrides a clear. The mask is moved between the halves so that each request line is tied to its own 16 pins.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned OFS_DOUT   = 32'h00;
  localparam int unsigned OFS_DIR    = 32'h04;
  localparam int unsigned OFS_PAD    = 32'h08;
  localparam int unsigned OFS_CFG_LO = 32'h0C;
  localparam int unsigned OFS_CFG_HI = 32'h10;
  localparam int unsigned OFS_MASK   = 32'h14;
  localparam int unsigned OFS_STAT   = 32'h18;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_mode_e;
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned STAGES   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] sync_o,
  output logic [NUM_PINS-1:0] prev_o
);
  logic [STAGES-1:0][NUM_PINS-1:0] stg_q;
  logic [NUM_PINS-1:0]             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= pad_i;
  end

  for (genvar gs = 1; gs < STAGES; gs++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[gs] <= '0;
      else         stg_q[gs] <= stg_q[gs-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= stg_q[STAGES-1];
  end

  assign sync_o = stg_q[STAGES-1];
  assign prev_o = prev_q;

  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  if (STAGES == 2) begin : g_chk2
    assert_sync_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q >= 2'd2) |-> (sync_o == $past(pad_i, 2)));
  end
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic [NUM_PINS-1:0]   cur_i,
  input  logic [NUM_PINS-1:0]   prev_i,
  input  logic [2*NUM_PINS-1:0] cfg_i,
  output logic [NUM_PINS-1:0]   hit_o
);
  for (genvar gp = 0; gp < NUM_PINS; gp++) begin : g_pin
    trig_mode_e mode;
    assign mode = trig_mode_e'(cfg_i[2*gp +: 2]);
    always_comb begin
      unique case (mode)
        TRIG_LOW:  hit_o[gp] = ~cur_i[gp];
        TRIG_HIGH: hit_o[gp] =  cur_i[gp];
        TRIG_RISE: hit_o[gp] =  cur_i[gp] & ~prev_i[gp];
        default:   hit_o[gp] = ~cur_i[gp] &  prev_i[gp];
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned AW       = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [AW-1:0]         addr_i,
  input  logic                  we_i,
  input  logic [NUM_PINS-1:0]   wdata_i,
  input  logic [NUM_PINS-1:0]   pad_sync_i,
  input  logic [NUM_PINS-1:0]   hit_i,
  output logic [NUM_PINS-1:0]   rdata_o,
  output logic [NUM_PINS-1:0]   dout_o,
  output logic [NUM_PINS-1:0]   dir_o,
  output logic [2*NUM_PINS-1:0] cfg_o,
  output logic [NUM_PINS-1:0]   mask_o,
  output logic [NUM_PINS-1:0]   status_o
);
  localparam int unsigned CFG_W = NUM_PINS;

  logic [NUM_PINS-1:0] dout_q, dir_q, mask_q, status_q, clr_vec;
  logic [CFG_W-1:0]    cfg_lo_q, cfg_hi_q;
  logic sel_dout, sel_dir, sel_cfg_lo, sel_cfg_hi, sel_mask, sel_stat;

  assign sel_dout   = we_i && (addr_i == AW'(OFS_DOUT));
  assign sel_dir    = we_i && (addr_i == AW'(OFS_DIR));
  assign sel_cfg_lo = we_i && (addr_i == AW'(OFS_CFG_LO));
  assign sel_cfg_hi = we_i && (addr_i == AW'(OFS_CFG_HI));
  assign sel_mask   = we_i && (addr_i == AW'(OFS_MASK));
  assign sel_stat   = we_i && (addr_i == AW'(OFS_STAT));
  assign clr_vec    = sel_stat ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
      status_q <= '0;
    end else begin
      if (sel_dout)   dout_q   <= wdata_i;
      if (sel_dir)    dir_q    <= wdata_i;
      if (sel_cfg_lo) cfg_lo_q <= wdata_i;
      if (sel_cfg_hi) cfg_hi_q <= wdata_i;
      if (sel_mask)   mask_q   <= wdata_i;
      // detection beats a same-cycle clear
      status_q <= (status_q & ~clr_vec) | hit_i;
    end
  end

  always_comb begin
    case (addr_i)
      AW'(OFS_DOUT):   rdata_o = dout_q;
      AW'(OFS_DIR):    rdata_o = dir_q;
      AW'(OFS_PAD):    rdata_o = pad_sync_i;
      AW'(OFS_CFG_LO): rdata_o = cfg_lo_q;
      AW'(OFS_CFG_HI): rdata_o = cfg_hi_q;
      AW'(OFS_MASK):   rdata_o = mask_q;
      AW'(OFS_STAT):   rdata_o = status_q;
      default:         rdata_o = '0;
    endcase
  end

  assign dout_o   = dout_q;
  assign dir_o    = dir_q;
  assign cfg_o    = {cfg_hi_q, cfg_lo_q};
  assign mask_o   = mask_q;
  assign status_o = status_q;

  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  assert_w1c_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q |-> (($past(status_q) & ~status_q & ~$past(clr_vec)) == '0));

  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q |-> ((status_q & $past(hit_i)) == $past(hit_i)));

  assert_dir_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && !$past(sel_dir)) |-> $stable(dir_q));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] pad_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic                irq_lo_o,
  output logic                irq_hi_o,
  output logic                irq_o
);
  localparam int unsigned HALF = NUM_PINS / 2;

  logic [NUM_PINS-1:0]   sync_s, prev_s, hit_s, dout_s, dir_s, mask_s, status_s, pend_s;
  logic [2*NUM_PINS-1:0] cfg_s;

  gpio_pad_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .pad_i, .sync_o(sync_s), .prev_o(prev_s)
  );

  gpio_trig_detect #(.NUM_PINS(NUM_PINS)) u_det (
    .cur_i(sync_s), .prev_i(prev_s), .cfg_i(cfg_s), .hit_o(hit_s)
  );

  gpio_irq_regs #(.NUM_PINS(NUM_PINS), .AW(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i,
    .pad_sync_i(sync_s), .hit_i(hit_s), .rdata_o,
    .dout_o(dout_s), .dir_o(dir_s), .cfg_o(cfg_s),
    .mask_o(mask_s), .status_o(status_s)
  );

  assign pad_o    = dout_s & dir_s;
  assign pad_oe_o = dir_s;
  assign pend_s   = status_s & mask_s;
  assign irq_lo_o = |pend_s[HALF-1:0];
  assign irq_hi_o = |pend_s[NUM_PINS-1:HALF];
  assign irq_o    = irq_lo_o | irq_hi_o;

  assert_irq_lo_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_lo_o |-> (mask_s[HALF-1:0] != '0));
  assert_irq_hi_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_hi_o |-> (mask_s[NUM_PINS-1:HALF] != '0));
endmodule

// File: tb/sim_gpio_irq_port.sv
module sim_gpio_irq_port;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [7:0]  addr;
  logic        we;
  logic [31:0] wdata, rdata, pad_i, pad_o, pad_oe;
  logic        irq_lo, irq_hi, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [1:0]  mode_m [32];
  logic [31:0] cur_pad, exp_st, mask_m;

  always #2 clk = ~clk;

  gpio_irq_port u0 (
    .clk_i(clk), .rst_ni, .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pad_i, .pad_o, .pad_oe_o(pad_oe),
    .irq_lo_o(irq_lo), .irq_hi_o(irq_hi), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  function automatic logic [31:0] lvl_hits(input logic [31:0] p);
    logic [31:0] r;
    for (int n = 0; n < 32; n++)
      r[n] = (mode_m[n] == 2'd0 && !p[n]) || (mode_m[n] == 2'd1 && p[n]);
    return r;
  endfunction

  function automatic logic [31:0] edge_hits(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    for (int n = 0; n < 32; n++)
      r[n] = (mode_m[n] == 2'd2 && !a[n] && b[n]) || (mode_m[n] == 2'd3 && a[n] && !b[n]);
    return r;
  endfunction

  task automatic drive_pad(input logic [31:0] v);
    logic [31:0] old;
    @(negedge clk); old = cur_pad; pad_i = v; cur_pad = v;
    repeat (4) @(negedge clk);
    exp_st |= edge_hits(old, v) | lvl_hits(v);
  endtask

  task automatic clear(input logic [31:0] m);
    wr(8'h18, m);
    exp_st = (exp_st & ~m) | lvl_hits(cur_pad);
  endtask

  task automatic check_status(input string tag);
    logic [31:0] d, pend;
    rd(8'h18, d);
    chk({tag, " status R5/R6/R7/R8"}, d, exp_st);
    pend = exp_st & mask_m;
    chk({tag, " irq R9"}, {29'd0, irq, irq_hi, irq_lo},
        {29'd0, |pend, |pend[31:16], |pend[15:0]});
  endtask

  task automatic set_modes(input int sel);
    logic [31:0] lo, hi, d;
    for (int n = 0; n < 32; n++)
      mode_m[n] = (sel < 4) ? 2'(sel) : (sel == 4) ? 2'((n * 5 + n / 4) % 4)
                                                   : 2'((3 * n + n / 8 + 1) % 4);
    for (int n = 0; n < 16; n++) begin
      lo[2*n +: 2] = mode_m[n];
      hi[2*n +: 2] = mode_m[n+16];
    end
    wr(8'h0C, lo); wr(8'h10, hi);
    rd(8'h0C, d); chk("cfg lo readback R4", d, lo);
    rd(8'h10, d); chk("cfg hi readback R4", d, hi);
    repeat (2) @(negedge clk);
    exp_st |= lvl_hits(cur_pad);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, x, p;
    rst_ni = 1'b0; addr = '0; we = 1'b0; wdata = '0; pad_i = '0;
    cur_pad = '0; mask_m = '0;
    for (int n = 0; n < 32; n++) mode_m[n] = 2'd0;
    exp_st = 32'hFFFF_FFFF;  // all pads low under low-level trigger
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1
    rd(8'h00, d); chk("reset dout R1", d, 0);
    rd(8'h04, d); chk("reset dir R1", d, 0);
    rd(8'h14, d); chk("reset mask R1", d, 0);
    rd(8'h0C, d); chk("reset cfg lo R1", d, 0);
    rd(8'h10, d); chk("reset cfg hi R1", d, 0);
    chk("reset pads R1", pad_oe | pad_o, 0);
    chk("reset irq R1", {29'd0, irq, irq_hi, irq_lo}, 0);

    // R2
    for (int k = 0; k < 3; k++) begin
      logic [31:0] a, b;
      a = 32'(32'hC3A5_5A3C * (k + 3)); b = 32'(32'h0F1E_2D3C ^ (32'h1357_9BDF << k));
      wr(8'h00, a); wr(8'h04, b);
      rd(8'h00, d); chk("dout readback R2", d, a);
      rd(8'h04, d); chk("dir readback R2", d, b);
      chk("pad_o R2", pad_o, a & b);
      chk("pad_oe R2", pad_oe, b);
    end

    // R3: two-edge latency, direction-independent, write ignored
    x = 32'h6B2D_F019;
    @(negedge clk); pad_i = x;
    @(negedge clk); rd(8'h08, d); chk("pad after 1 edge R3", d, 32'h0);
    @(negedge clk); rd(8'h08, d); chk("pad after 2 edges R3", d, x);
    cur_pad = x; exp_st |= lvl_hits(x);
    wr(8'h08, ~x); rd(8'h08, d); chk("pad write ignored R3", d, x);

    // trigger sweep
    for (int sel = 0; sel < 6; sel++) begin
      set_modes(sel);
      mask_m = (sel % 2 == 0) ? 32'h0000_FFFF : 32'hFFFF_0000;
      if (sel >= 4) mask_m = 32'h8421_1248 << sel;
      wr(8'h14, mask_m);
      rd(8'h14, d); chk("mask readback R9", d, mask_m);
      drive_pad(32'h0);
      clear(32'hFFFF_FFFF);
      check_status("after full clear");
      wr(8'h18, 32'h0);  // R7 write zero: no change
      check_status("zero write");
      for (int k = 0; k < 6; k++) begin
        p = 32'(32'h9E37_79B9 * (k + 1)) ^ (32'h0000_FFFF << k);
        drive_pad(p);
        check_status("after pad change");
        clear(p ^ 32'h0F0F_0F0F);
        check_status("after partial clear");
      end
    end

    // R8 explicit: high level held, clear cannot drop it
    set_modes(1);
    drive_pad(32'hFFFF_FFFF);
    clear(32'hFFFF_FFFF);
    rd(8'h18, d); chk("level held over clear R8", d, 32'hFFFF_FFFF);

    // R10
    rd(8'h1C, d); chk("unmapped 0x1C R10", d, 0);
    rd(8'h20, d); chk("unmapped 0x20 R10", d, 0);
    rd(8'h02, d); chk("misaligned 0x02 R10", d, 0);
    rd(8'hFC, d); chk("unmapped 0xFC R10", d, 0);
    wr(8'h00, 32'h1234_5678); wr(8'h04, 32'h00FF_00FF); wr(8'h14, 32'h0000_0001);
    wr(8'h1C, 32'hFFFF_FFFF); wr(8'h01, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("dout after stray write R10", d, 32'h1234_5678);
    rd(8'h04, d); chk("dir after stray write R10", d, 32'h00FF_00FF);
    rd(8'h14, d); chk("mask after stray write R10", d, 32'h0000_0001);
    rd(8'h10, d); chk("cfg hi after stray write R10", d, 32'h5555_5555);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule